// File: doc/BRIEF.md
# Trusted-Module Register Window Model

This block models the device side of a security-module register window. A host reaches it through a byte-wide memory-mapped port with a 12-bit address, one byte per access, with no wait states. It has a single locality with a request/grant handshake. It runs a command handshake through a status byte and reports a 16-bit burst count as two separate bytes. Command and response bytes pass through a single data port.

Inside, a small phase machine moves from idle to ready, then receiving, executing and completion. The length of each command is taken from the big-endian size field in bytes 2 to 5 of that command. No real command processing is done. After a programmable delay, a loopback responder returns a fixed response header followed by an echo of the command payload. The model is meant to stand in for the real device when host-side driver logic or firmware flows are exercised.

Top module: `tis_regs_model`

## Requirements
- R1: After reset the access byte (offset 0x00) reads 0x81, the status byte (0x18) reads 0x80 and both burst bytes read 0. Writing the access byte with bit1 (request use) set makes it read 0xA1 (bit7 valid, bit5 active, bit0 establishment). Writing it with bit5 set releases the locality, and it reads 0x81 again.
- R2: While dev_present is low, every read returns 0xFF and every write is ignored.
- R3: Writing the status byte with bit6 set enters the ready phase from any phase. The status byte then reads 0xC0 (valid and ready) and the burst count equals BUF_DEPTH.
- R4: In the ready phase, the first write to the data port (0x24) starts reception, and status bit3 (expect) reads 1. Expect stays 1 until the number of received bytes reaches the command length. That length is the big-endian size in command bytes 2 to 5, clamped to no less than 10 and no more than BUF_DEPTH. Once the length is reached the status reads 0x80, and further data-port writes are ignored.
- R5: The burst count is read low byte at 0x19 and high byte at 0x1A. It equals BUF_DEPTH minus the bytes received while expect is 1, equals the response bytes left to read during completion, and is 0 in every other phase.
- R6: Writing status bit5 (go) once a command is fully received starts execution. Status then reads 0x80 and the burst count reads 0 until about EXEC_DELAY cycles have passed, after which status reads 0x90 (valid and data available). A go write at any other time is ignored.
- R7: The response is laid out as follows:
  - bytes 0 and 1 are 0x00, 0xC4;
  - bytes 2 to 5 are the command length, big-endian;
  - bytes 6 to 9 are zero;
  - every later byte repeats the command byte at the same position.
- R8: Status bit4 (data available) stays set until the last response byte has been read. Status then reads 0x80, and further data-port reads return 0xFF.
- R9: In the completion phase, writing status bit1 (retry) rewinds the response so that the next data-port read returns response byte 0.
- R10: The identifier bytes read VENDOR_ID low/high at 0xF00/0xF01, DEVICE_ID low/high at 0xF02/0xF03 and REV_ID at 0xF04. Any other unmapped offset, such as 0x08, reads 0x00.
- R11: A ready write in the middle of reception or of response readout abandons that phase, empties the buffer pointers and returns to ready (status 0xC0, burst BUF_DEPTH).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_present | input | 1 | Device attached; when low all reads give 0xFF |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; data appears on the next cycle |
| bus_rdata | output | 8 | Registered read data |

## Verification
The embedded properties check the following on every cycle:
- a locality grant follows a request in the next cycle;
- a ready write always lands in the ready phase with empty pointers;
- execution is entered only from a fully received command;
- the buffer pointers never run past their limits;
- an absent device always answers 0xFF.

Other behaviours need whole transactions, and only the bench scenarios can show them:
- the length clamping at both ends;
- the response byte layout and the echoed payload;
- the retry rewind;
- aborting partway through reception or readout;
- the point at which expect and data available change within a command.

// File: rtl/tis_pkg.sv
package tis_pkg;
  localparam int unsigned OFF_ACCESS = 'h000;
  localparam int unsigned OFF_STATUS = 'h018;
  localparam int unsigned OFF_BURST_LO = 'h019;
  localparam int unsigned OFF_BURST_HI = 'h01A;
  localparam int unsigned OFF_DATA = 'h024;
  localparam int unsigned OFF_VID_LO = 'hF00;
  localparam int unsigned OFF_VID_HI = 'hF01;
  localparam int unsigned OFF_DID_LO = 'hF02;
  localparam int unsigned OFF_DID_HI = 'hF03;
  localparam int unsigned OFF_REV = 'hF04;

  // bit positions the host decodes
  localparam int unsigned ACC_REQ_BIT = 1;
  localparam int unsigned ACC_ACT_BIT = 5;
  localparam int unsigned STS_RETRY_BIT = 1;
  localparam int unsigned STS_GO_BIT = 5;
  localparam int unsigned STS_RDY_BIT = 6;

  localparam int unsigned HDR_BYTES = 10;
  localparam int unsigned SIZE_FIRST = 2;
  localparam int unsigned SIZE_LAST = 5;
  localparam logic [15:0] RSP_TAG = 16'h00C4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READY,
    PH_RECV,
    PH_EXEC,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/tis_access.sv
module tis_access (
  input  logic clk,
  input  logic rst,
  input  logic req_wr,
  input  logic rel_wr,
  output logic active
);
  always_ff @(posedge clk) begin
    if (rst) active <= 1'b0;
    else if (req_wr) active <= 1'b1;
    else if (rel_wr) active <= 1'b0;
  end

  p_grant_r1: assert property (@(posedge clk) disable iff (rst)
    req_wr |=> active);
  p_release_r1: assert property (@(posedge clk) disable iff (rst)
    (rel_wr && !req_wr) |=> !active);
endmodule

// File: rtl/tis_cmd_buf.sv
module tis_cmd_buf #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tis_exec_timer.sv
module tis_exec_timer #(
  parameter int unsigned DELAY = 8,
  localparam int unsigned D = (DELAY < 1) ? 1 : DELAY,
  localparam int unsigned CW = $clog2(D + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic done
);
  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      done <= 1'b0;
    end else if (busy) begin
      if (cnt == CW'(D - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(D - 1));
endmodule

// File: rtl/tis_regs_model.sv
module tis_regs_model
  import tis_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BUF_DEPTH = 64,
  parameter int unsigned EXEC_DELAY = 8,
  parameter logic [15:0] VENDOR_ID = 16'h1D5A,
  parameter logic [15:0] DEVICE_ID = 16'h0012,
  parameter logic [7:0] REV_ID = 8'h03,
  localparam int unsigned AW = $clog2(BUF_DEPTH),
  localparam int unsigned PW = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_present,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata
);
  phase_t        phase;
  logic [PW-1:0] wr_ptr, rd_ptr, cmd_len;
  logic [31:0]   size_q, len32;
  logic          active, exec_done, cmd_done;
  logic [7:0]    buf_q, acc_byte, sts_byte, data_byte;
  logic [15:0]   burst;

  wire acc_wr  = bus_wr && dev_present && bus_addr == ADDR_W'(OFF_ACCESS);
  wire sts_wr  = bus_wr && dev_present && bus_addr == ADDR_W'(OFF_STATUS);
  wire data_wr = bus_wr && dev_present && bus_addr == ADDR_W'(OFF_DATA);
  wire data_rd = bus_rd && dev_present && bus_addr == ADDR_W'(OFF_DATA);
  wire go_ready = sts_wr && bus_wdata[STS_RDY_BIT];
  wire go_exec  = sts_wr && bus_wdata[STS_GO_BIT] && !go_ready
                  && phase == PH_RECV && cmd_done;

  // command length from the size field, clamped to [header, depth]
  always_comb begin
    if (size_q < 32'(HDR_BYTES)) cmd_len = PW'(HDR_BYTES);
    else if (size_q > 32'(BUF_DEPTH)) cmd_len = PW'(BUF_DEPTH);
    else cmd_len = size_q[PW-1:0];
  end
  assign len32    = 32'(cmd_len);
  assign cmd_done = (wr_ptr > PW'(SIZE_LAST)) && (wr_ptr >= cmd_len);

  wire take_byte = data_wr && !go_ready &&
                   (phase == PH_READY || (phase == PH_RECV && !cmd_done
                                          && wr_ptr < PW'(BUF_DEPTH)));
  wire [AW-1:0] waddr = (phase == PH_READY) ? '0 : wr_ptr[AW-1:0];

  tis_access u_access (
    .clk    (clk),
    .rst    (rst),
    .req_wr (acc_wr && bus_wdata[ACC_REQ_BIT]),
    .rel_wr (acc_wr && bus_wdata[ACC_ACT_BIT]),
    .active (active)
  );

  tis_cmd_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk   (clk),
    .we    (take_byte),
    .waddr (waddr),
    .wdata (bus_wdata),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (buf_q)
  );

  tis_exec_timer #(.DELAY(EXEC_DELAY)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (go_exec),
    .abort (go_ready),
    .done  (exec_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      wr_ptr <= '0;
      rd_ptr <= '0;
      size_q <= '0;
    end else if (go_ready) begin
      phase  <= PH_READY;
      wr_ptr <= '0;
      rd_ptr <= '0;
      size_q <= '0;
    end else begin
      if (take_byte) begin
        wr_ptr <= (phase == PH_READY) ? PW'(1) : wr_ptr + 1'b1;
        if (phase == PH_RECV && wr_ptr >= PW'(SIZE_FIRST) && wr_ptr <= PW'(SIZE_LAST))
          size_q <= {size_q[23:0], bus_wdata};
      end
      unique case (phase)
        PH_READY: if (take_byte) phase <= PH_RECV;
        PH_RECV:  if (go_exec) phase <= PH_EXEC;
        PH_EXEC:  if (exec_done) phase <= PH_DONE;
        PH_DONE: begin
          if (sts_wr && bus_wdata[STS_RETRY_BIT]) rd_ptr <= '0;
          else if (data_rd && rd_ptr < cmd_len) rd_ptr <= rd_ptr + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign acc_byte = {1'b1, 1'b0, active, 4'b0000, 1'b1};
  assign sts_byte = {1'b1, phase == PH_READY, 1'b0,
                     phase == PH_DONE && rd_ptr < cmd_len,
                     phase == PH_RECV && !cmd_done, 3'b000};

  always_comb begin
    if (phase == PH_READY) burst = 16'(BUF_DEPTH);
    else if (phase == PH_RECV && !cmd_done) burst = 16'(PW'(BUF_DEPTH) - wr_ptr);
    else if (phase == PH_DONE) burst = 16'(cmd_len - rd_ptr);
    else burst = '0;
  end

  always_comb begin
    if (phase != PH_DONE || rd_ptr >= cmd_len) data_byte = 8'hFF;
    else if (rd_ptr >= PW'(HDR_BYTES)) data_byte = buf_q;
    else begin
      case (rd_ptr)
        PW'(0): data_byte = RSP_TAG[15:8];
        PW'(1): data_byte = RSP_TAG[7:0];
        PW'(2): data_byte = len32[31:24];
        PW'(3): data_byte = len32[23:16];
        PW'(4): data_byte = len32[15:8];
        PW'(5): data_byte = len32[7:0];
        default: data_byte = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 8'h00;
    else if (bus_rd) begin
      if (!dev_present) bus_rdata <= 8'hFF;
      else begin
        case (bus_addr)
          ADDR_W'(OFF_ACCESS):   bus_rdata <= acc_byte;
          ADDR_W'(OFF_STATUS):   bus_rdata <= sts_byte;
          ADDR_W'(OFF_BURST_LO): bus_rdata <= burst[7:0];
          ADDR_W'(OFF_BURST_HI): bus_rdata <= burst[15:8];
          ADDR_W'(OFF_DATA):     bus_rdata <= data_byte;
          ADDR_W'(OFF_VID_LO):   bus_rdata <= VENDOR_ID[7:0];
          ADDR_W'(OFF_VID_HI):   bus_rdata <= VENDOR_ID[15:8];
          ADDR_W'(OFF_DID_LO):   bus_rdata <= DEVICE_ID[7:0];
          ADDR_W'(OFF_DID_HI):   bus_rdata <= DEVICE_ID[15:8];
          ADDR_W'(OFF_REV):      bus_rdata <= REV_ID;
          default:               bus_rdata <= 8'h00;
        endcase
      end
    end
  end

  p_abort_ready_r11: assert property (@(posedge clk) disable iff (rst)
    go_ready |=> (phase == PH_READY && wr_ptr == '0 && rd_ptr == '0));
  p_exec_entry_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && $past(phase) != PH_EXEC) |->
      ($past(phase) == PH_RECV && $past(cmd_done)));
  p_wr_bound_r4: assert property (@(posedge clk) disable iff (rst)
    wr_ptr <= PW'(BUF_DEPTH));
  p_rd_bound_r8: assert property (@(posedge clk) disable iff (rst)
    rd_ptr <= cmd_len);
  p_absent_ff_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !dev_present) |=> bus_rdata == 8'hFF);
endmodule

// File: tb/tis_regs_model_bench.sv
module tis_regs_model_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int DELAY = 8;
  localparam logic [15:0] VID = 16'h1D5A;
  localparam logic [15:0] DID = 16'h0012;
  localparam logic [7:0]  RID = 8'h03;
  localparam logic [11:0] A_ACC = 12'h000, A_STS = 12'h018, A_BLO = 12'h019,
                          A_BHI = 12'h01A, A_DAT = 12'h024;

  logic clk = 1'b0, rst = 1'b1, dev_present = 1'b1;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, rd_chk = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  int n_checks = 0, n_fail = 0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tis_regs_model #(.ADDR_W(12), .BUF_DEPTH(DEPTH), .EXEC_DELAY(DELAY),
                   .VENDOR_ID(VID), .DEVICE_ID(DID), .REV_ID(RID)) u_tis_regs_model (
    .clk(clk), .rst(rst), .dev_present(dev_present), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a checked read returns
  initial forever begin
    @(posedge clk);
    if (bus_rd && rd_chk) begin
      exp_t e;
      @(negedge clk);
      e = q.pop_front();
      chk(bus_rdata == e.exp, e.tag, bus_rdata, e.exp);
    end
  end

  task automatic rd(input logic [11:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; rd_chk = 1'b1;
    q.push_back('{e, tag});
    @(negedge clk);
    bus_rd = 1'b0; rd_chk = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    v = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  function automatic logic [7:0] cmd_byte(input int i, input logic [31:0] size);
    case (i)
      0: return 8'h00;
      1: return 8'hC1;
      2: return size[31:24];
      3: return size[23:16];
      4: return size[15:8];
      5: return size[7:0];
      default: return 8'(i * 7 + 1);
    endcase
  endfunction

  function automatic logic [7:0] rsp_byte(input int i, input logic [31:0] len);
    if (i == 1) return 8'hC4;
    if (i >= 2 && i <= 5) return len[8*(5-i) +: 8];
    if (i < 10) return 8'h00;
    return cmd_byte(i, 0);
  endfunction

  task automatic send(input int from, input int to, input logic [31:0] size);
    for (int i = from; i < to; i++) wr(A_DAT, cmd_byte(i, size));
  endtask

  task automatic wait_data(input string tag);
    logic [7:0] v = 8'h00;
    for (int k = 0; k < 40; k++) begin
      peek(A_STS, v);
      if (v == 8'h90) break;
    end
    chk(v == 8'h90, tag, v, 8'h90);
  endtask

  task automatic read_rsp(input int n, input logic [31:0] len, input string tag);
    for (int i = 0; i < n; i++) rd(A_DAT, rsp_byte(i, len), tag);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(A_ACC, 8'h81, "R1 reset access");
    rd(A_STS, 8'h80, "R1 reset status");
    rd(A_BLO, 8'h00, "R1 reset burst lo");
    rd(A_BHI, 8'h00, "R1 reset burst hi");
    // R10 identifiers
    rd(12'hF00, VID[7:0], "R10 vid lo");
    rd(12'hF01, VID[15:8], "R10 vid hi");
    rd(12'hF02, DID[7:0], "R10 did lo");
    rd(12'hF03, DID[15:8], "R10 did hi");
    rd(12'hF04, RID, "R10 rev");
    rd(12'h008, 8'h00, "R10 unmapped");
    // R1 locality request and release
    wr(A_ACC, 8'h02); rd(A_ACC, 8'hA1, "R1 granted");
    wr(A_ACC, 8'h20); rd(A_ACC, 8'h81, "R1 released");
    wr(A_ACC, 8'h02); rd(A_ACC, 8'hA1, "R1 regranted");
    // R3 ready
    wr(A_STS, 8'h40);
    rd(A_STS, 8'hC0, "R3 ready status");
    rd(A_BLO, 8'(DEPTH), "R3 burst lo");
    rd(A_BHI, 8'h00, "R3 burst hi");
    // R4 reception of a 14-byte command
    send(0, 1, 14);
    rd(A_STS, 8'h88, "R4 expect after first");
    rd(A_BLO, 8'(DEPTH - 1), "R5 burst while receiving");
    send(1, 6, 14);
    wr(A_STS, 8'h20);
    rd(A_STS, 8'h88, "R6 early go ignored");
    send(6, 14, 14);
    rd(A_STS, 8'h80, "R4 expect cleared");
    rd(A_BLO, 8'h00, "R5 burst zero when complete");
    wr(A_DAT, 8'h55);
    rd(A_STS, 8'h80, "R4 extra byte ignored");
    // R6 execution
    wr(A_STS, 8'h20);
    rd(A_STS, 8'h80, "R6 executing status");
    rd(A_BLO, 8'h00, "R6 executing burst");
    wait_data("R6 data available");
    rd(A_BLO, 8'd14, "R5 burst in completion");
    // R7 / R8 response readout
    read_rsp(3, 14, "R7 response");
    rd(A_BLO, 8'd11, "R5 burst after 3 reads");
    for (int i = 3; i < 13; i++) rd(A_DAT, rsp_byte(i, 14), "R7 response");
    rd(A_STS, 8'h90, "R8 data held before last");
    rd(A_DAT, rsp_byte(13, 14), "R7 last byte");
    rd(A_STS, 8'h80, "R8 data cleared");
    rd(A_DAT, 8'hFF, "R8 read past end");
    rd(A_BLO, 8'h00, "R5 burst drained");
    // R9 retry
    wr(A_STS, 8'h02);
    rd(A_STS, 8'h90, "R9 retry status");
    rd(A_DAT, 8'h00, "R9 retry byte0");
    rd(A_DAT, 8'hC4, "R9 retry byte1");
    rd(A_BLO, 8'd12, "R9 retry burst");
    // R11 abort during readout
    wr(A_STS, 8'h40);
    rd(A_STS, 8'hC0, "R11 abort readout");
    rd(A_BLO, 8'(DEPTH), "R11 burst after abort");
    // R4 lower clamp: size 4 -> length 10
    send(0, 9, 4);
    rd(A_STS, 8'h88, "R4 clamp low pending");
    send(9, 10, 4);
    rd(A_STS, 8'h80, "R4 clamp low done");
    wr(A_STS, 8'h20);
    wait_data("R6 second command");
    read_rsp(10, 10, "R7 short response");
    rd(A_STS, 8'h80, "R8 short drained");
    // R11 abort during reception
    wr(A_STS, 8'h40);
    send(0, 3, 20);
    rd(A_STS, 8'h88, "R11 receiving");
    wr(A_STS, 8'h40);
    rd(A_STS, 8'hC0, "R11 abort receive");
    rd(A_BLO, 8'(DEPTH), "R11 burst reset");
    // R4 upper clamp: size 0x1000 -> length DEPTH
    send(0, DEPTH - 1, 32'h1000);
    rd(A_STS, 8'h88, "R4 clamp high pending");
    rd(A_BLO, 8'h01, "R5 one byte left");
    send(DEPTH - 1, DEPTH, 32'h1000);
    rd(A_STS, 8'h80, "R4 clamp high done");
    wr(A_STS, 8'h20);
    wait_data("R6 full command");
    rd(A_BLO, 8'(DEPTH), "R5 full burst");
    read_rsp(DEPTH, DEPTH, "R7 full response");
    rd(A_STS, 8'h80, "R8 full drained");
    // R2 absent device
    dev_present = 1'b0;
    rd(A_ACC, 8'hFF, "R2 absent access");
    rd(A_STS, 8'hFF, "R2 absent status");
    rd(12'hF00, 8'hFF, "R2 absent vid");
    wr(A_STS, 8'h40);
    wr(A_ACC, 8'h20);
    dev_present = 1'b1;
    rd(A_STS, 8'h80, "R2 status write ignored");
    rd(A_ACC, 8'hA1, "R2 access write ignored");
    repeat (4) @(negedge clk);
    summary();
  end
endmodule